// File: doc/BRIEF.md
# Three-Class Stratified Round-Robin Packet Scheduler

This block decides which packet descriptor leaves next toward an egress queue. Descriptors (a length, plus the class and flow they belong to) are written into small per-queue FIFOs held inside the block. There are three traffic classes: real-time, non-real-time and best-effort. The real-time class owns two queues that stand for two consecutive deadline intervals. The non-real-time and best-effort classes each own `FLOWS` per-flow queues.

Link time is cut into a repeating frame of six slots. The slot classes are, in this order: real-time, non-real-time, real-time, non-real-time, real-time, best-effort. Real-time traffic therefore holds half of the slots, non-real-time a third and best-effort a sixth. Each slot starts with a byte budget taken from a configuration input. In a real-time slot the earlier-deadline queue is served before the later one. In the other two classes, flows are visited in turn under deficit round robin, with a per-flow quantum from a configuration input. A slot whose own class has nothing queued is handed to best-effort flows, so the block keeps sending while anything is queued.

The scheduler takes at most one step per clock, and only in cycles where the egress side asserts ready. A step either emits one descriptor into the output register or updates the state (next slot, credit a flow, move to the next flow). The work done per step does not depend on the number of flows.

Top module: `tri_class_scheduler`

## Requirements
- R1: An enqueue with class code 0 goes to a real-time queue: sub 0 is the earlier-deadline queue (output queue id 0) and sub 1 the later one (id 1). Class code 1 goes to non-real-time flow `sub` (id 2+sub). Class code 2 goes to best-effort flow `sub` (id 2+FLOWS+sub). Every accepted descriptor leaves exactly once, with its length, in FIFO order within its queue.
- R2: Class code 3 is not a valid class. For that code `enq_ready` is low and the descriptor is dropped.
- R3: Slots repeat in the order real-time, non-real-time, real-time, non-real-time, real-time, best-effort, starting from the first slot after reset. Each slot starts with a budget of `cfg_slot_budget` bytes.
- R4: In a real-time slot the earlier-deadline queue is drained first. The later queue is served only while the earlier one is empty.
- R5: A descriptor is sent only if its length does not exceed the budget left in the slot. The first descriptor of a slot is always allowed. A descriptor that does not fit ends the slot and waits for a later slot of its class. A slot also ends when it has nothing left that it may serve.
- R6: On arriving at a flow, the scheduler adds the flow's quantum to the flow's deficit once. The flow sends while its head length does not exceed its deficit, and each send subtracts the length. Unused deficit is kept when the scheduler moves on because the head is too long. The deficit is cleared when the flow's queue becomes empty.
- R7: A real-time or non-real-time slot with no backlog in its own class serves best-effort flows instead. While any queue holds a descriptor and the egress side is ready, descriptors keep coming out.
- R8: A descriptor shown on the output holds `deq_valid`, `deq_queue` and `deq_len` steady until `deq_ready` is high. The scheduler takes no step in a cycle where `deq_ready` is low.
- R9: After reset `deq_valid` is low and all queues are empty.
- R10: A queue holds at most `DEPTH` descriptors. When the target queue is full, `enq_ready` is low and the descriptor is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Descriptor offered for enqueue |
| enq_class | input | 2 | Class code: 0 real-time, 1 non-real-time, 2 best-effort |
| enq_sub | input | $clog2(FLOWS) | Flow index, or deadline interval for real-time |
| enq_len | input | LENW | Packet length in bytes |
| enq_ready | output | 1 | Descriptor accepted this cycle if enq_valid is high |
| cfg_slot_budget | input | BW | Byte budget given to each slot |
| cfg_quantum | input | 2*FLOWS*LENW | Per-flow quantum; field j covers bits j*LENW upward; non-real-time flows first, then best-effort |
| deq_valid | output | 1 | A descriptor is presented |
| deq_ready | input | 1 | Egress accepts the descriptor; scheduler may step |
| deq_queue | output | $clog2(2+2*FLOWS) | Queue id of the presented descriptor |
| deq_len | output | LENW | Length of the presented descriptor |

## Verification
The bench goes after the places where a near-miss design gives a different order of departures. If the deadline queues are served in the wrong order, later-deadline packets come out first. If the slot budget is not enforced, a second real-time packet comes out before a best-effort packet that should take the free non-real-time slot. If deficits are not cleared on emptying, a refilled flow sends two packets where it should send one. Random loads with random budgets and quanta are compared against a bench model of the frame. Directed cases cover a full queue, an invalid class and output stalls, which check for a dropped descriptor, an extra descriptor and a descriptor that changes while stalled.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

    localparam int FRAME_LEN = 6;

    typedef enum logic [1:0] {
        CL_RT   = 2'd0,
        CL_NRT  = 2'd1,
        CL_BE   = 2'd2,
        CL_NONE = 2'd3
    } cls_t;

    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_NEXT_SLOT,
        ACT_CREDIT,
        ACT_SKIP,
        ACT_SEND
    } act_t;

    // Class owning each position of the slot frame.
    function automatic cls_t slot_class(input logic [2:0] s);
        case (s)
            3'd0, 3'd2, 3'd4: slot_class = CL_RT;
            3'd1, 3'd3:       slot_class = CL_NRT;
            default:          slot_class = CL_BE;
        endcase
    endfunction

endpackage

// File: rtl/tcs_fifo.sv
module tcs_fifo #(
    parameter int WIDTH = 10,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full,
    output logic             last
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_q, rd_q;
    logic [CW-1:0]    cnt_q;

    always_ff @(posedge clk) begin
        if (push) mem[wr_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= wr_q + 1'b1;
            if (pop)  rd_q <= rd_q + 1'b1;
            cnt_q <= cnt_q + CW'(push) - CW'(pop);
        end
    end

    assign head  = mem[rd_q];
    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CW'(DEPTH));
    assign last  = (cnt_q == CW'(1));
endmodule

// File: rtl/tcs_engine.sv
module tcs_engine
    import tcs_pkg::*;
#(
    parameter int LENW  = 10,
    parameter int BW    = 12,
    parameter int FLOWS = 2,
    parameter int NQ    = 6,
    parameter int QIDW  = 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          step_en,
    input  logic [NQ-1:0]                 q_ne,
    input  logic [NQ-1:0]                 q_last,
    input  logic [NQ-1:0]                 q_push,
    input  logic [NQ-1:0][LENW-1:0]       q_head,
    input  logic [BW-1:0]                 cfg_budget,
    input  logic [2*FLOWS-1:0][LENW-1:0]  cfg_quantum,
    output logic [NQ-1:0]                 q_pop,
    output logic                          send,
    output logic [QIDW-1:0]               send_qid,
    output logic [LENW-1:0]               send_len
);
    localparam int FW  = $clog2(FLOWS);
    localparam int DW  = LENW + 1;
    localparam int ND  = 2 * FLOWS;
    localparam int DIW = FW + 1;

    // Frame position and slot budget
    logic [2:0]               slot_q;
    logic [BW-1:0]            budget_q;
    logic                     fresh_q;
    // Deficit round robin state, index 0 = non-real-time, 1 = best-effort
    logic [1:0][FW-1:0]       ptr_q;
    logic [1:0]               cred_q;
    logic [ND-1:0][DW-1:0]    def_q;

    logic                     f1_bl, f2_bl, f3_bl;
    cls_t                     slot_cls, eff;
    logic                     be_sel;
    logic [DIW-1:0]           drr_idx;
    logic [QIDW-1:0]          sel_q;
    logic [LENW-1:0]          sel_len;
    logic [BW-1:0]            len_b;
    logic                     fits, covers, drained;
    act_t                     act;

    always_comb begin
        f1_bl    = |q_ne[1:0];
        f2_bl    = |q_ne[2 +: FLOWS];
        f3_bl    = |q_ne[2+FLOWS +: FLOWS];
        slot_cls = slot_class(slot_q);

        eff = CL_NONE;
        if (slot_cls == CL_RT && f1_bl)        eff = CL_RT;
        else if (slot_cls == CL_NRT && f2_bl)  eff = CL_NRT;
        else if (f3_bl)                        eff = CL_BE;

        be_sel  = (eff == CL_BE);
        drr_idx = {be_sel, ptr_q[be_sel]};
        if (eff == CL_RT) sel_q = q_ne[0] ? QIDW'(0) : QIDW'(1);
        else              sel_q = QIDW'(2) + QIDW'(drr_idx);

        sel_len = q_head[sel_q];
        len_b   = BW'(sel_len);
        fits    = fresh_q || (len_b <= budget_q);
        covers  = DW'(sel_len) <= def_q[drr_idx];
        drained = q_last[sel_q] && !q_push[sel_q];

        act = ACT_IDLE;
        if (step_en && (f1_bl || f2_bl || f3_bl)) begin
            if (eff == CL_NONE)          act = ACT_NEXT_SLOT;
            else if (eff == CL_RT)       act = fits ? ACT_SEND : ACT_NEXT_SLOT;
            else if (!q_ne[sel_q])       act = ACT_SKIP;
            else if (!cred_q[be_sel])    act = ACT_CREDIT;
            else if (!covers)            act = ACT_SKIP;
            else if (!fits)              act = ACT_NEXT_SLOT;
            else                         act = ACT_SEND;
        end
    end

    always_comb begin
        q_pop = '0;
        if (act == ACT_SEND) q_pop[sel_q] = 1'b1;
    end

    assign send     = (act == ACT_SEND);
    assign send_qid = sel_q;
    assign send_len = sel_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q   <= '0;
            budget_q <= cfg_budget;
            fresh_q  <= 1'b1;
            ptr_q    <= '0;
            cred_q   <= '0;
            def_q    <= '0;
        end else begin
            case (act)
                ACT_NEXT_SLOT: begin
                    slot_q   <= (slot_q == 3'(FRAME_LEN - 1)) ? 3'd0 : slot_q + 3'd1;
                    budget_q <= cfg_budget;
                    fresh_q  <= 1'b1;
                end
                ACT_CREDIT: begin
                    def_q[drr_idx]  <= def_q[drr_idx] + DW'(cfg_quantum[drr_idx]);
                    cred_q[be_sel]  <= 1'b1;
                end
                ACT_SKIP: begin
                    if (!q_ne[sel_q]) def_q[drr_idx] <= '0;
                    ptr_q[be_sel]  <= ptr_q[be_sel] + 1'b1;
                    cred_q[be_sel] <= 1'b0;
                end
                ACT_SEND: begin
                    budget_q <= (len_b <= budget_q) ? budget_q - len_b : '0;
                    fresh_q  <= 1'b0;
                    if (eff != CL_RT) begin
                        if (drained) begin
                            def_q[drr_idx] <= '0;
                            ptr_q[be_sel]  <= ptr_q[be_sel] + 1'b1;
                            cred_q[be_sel] <= 1'b0;
                        end else begin
                            def_q[drr_idx] <= def_q[drr_idx] - DW'(sel_len);
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tri_class_scheduler.sv
module tri_class_scheduler #(
    parameter int LENW  = 10,
    parameter int BW    = 12,
    parameter int FLOWS = 2,
    parameter int DEPTH = 4,
    localparam int FW   = $clog2(FLOWS),
    localparam int NQ   = 2 + 2 * FLOWS,
    localparam int QIDW = $clog2(NQ)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     enq_valid,
    input  logic [1:0]               enq_class,
    input  logic [FW-1:0]            enq_sub,
    input  logic [LENW-1:0]          enq_len,
    output logic                     enq_ready,
    input  logic [BW-1:0]            cfg_slot_budget,
    input  logic [2*FLOWS*LENW-1:0]  cfg_quantum,
    output logic                     deq_valid,
    input  logic                     deq_ready,
    output logic [QIDW-1:0]          deq_queue,
    output logic [LENW-1:0]          deq_len
);
    logic [NQ-1:0]            q_push, q_pop, q_empty, q_full, q_last, q_ne;
    logic [NQ-1:0][LENW-1:0]  q_head;
    logic [2*FLOWS-1:0][LENW-1:0] quantum;
    logic [QIDW-1:0]          tgt;
    logic                     tgt_ok;
    logic                     send;
    logic [QIDW-1:0]          send_qid;
    logic [LENW-1:0]          send_len;

    assign quantum = cfg_quantum;

    always_comb begin
        tgt_ok = 1'b1;
        tgt    = '0;
        case (enq_class)
            2'd0:    tgt = QIDW'(enq_sub[0]);
            2'd1:    tgt = QIDW'(2) + QIDW'(enq_sub);
            2'd2:    tgt = QIDW'(2 + FLOWS) + QIDW'(enq_sub);
            default: tgt_ok = 1'b0;
        endcase
    end

    assign enq_ready = tgt_ok && !q_full[tgt];

    always_comb begin
        q_push = '0;
        if (enq_valid && enq_ready) q_push[tgt] = 1'b1;
    end

    for (genvar i = 0; i < NQ; i++) begin : g_q
        tcs_fifo #(.WIDTH(LENW), .DEPTH(DEPTH)) u_fifo (
            .clk   (clk),
            .rst   (rst),
            .push  (q_push[i]),
            .pop   (q_pop[i]),
            .din   (enq_len),
            .head  (q_head[i]),
            .empty (q_empty[i]),
            .full  (q_full[i]),
            .last  (q_last[i])
        );
    end

    assign q_ne = ~q_empty;

    tcs_engine #(
        .LENW(LENW), .BW(BW), .FLOWS(FLOWS), .NQ(NQ), .QIDW(QIDW)
    ) u_engine (
        .clk         (clk),
        .rst         (rst),
        .step_en     (deq_ready),
        .q_ne        (q_ne),
        .q_last      (q_last),
        .q_push      (q_push),
        .q_head      (q_head),
        .cfg_budget  (cfg_slot_budget),
        .cfg_quantum (quantum),
        .q_pop       (q_pop),
        .send        (send),
        .send_qid    (send_qid),
        .send_len    (send_len)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            deq_valid <= 1'b0;
            deq_queue <= '0;
            deq_len   <= '0;
        end else if (send) begin
            deq_valid <= 1'b1;
            deq_queue <= send_qid;
            deq_len   <= send_len;
        end else if (deq_ready) begin
            deq_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/tcs_checker.sv
module tcs_checker #(
    parameter int NQ   = 6,
    parameter int QIDW = 3,
    parameter int LENW = 10
) (
    input logic            clk,
    input logic            rst,
    input logic [1:0]      enq_class,
    input logic            enq_ready,
    input logic            deq_valid,
    input logic            deq_ready,
    input logic [QIDW-1:0] deq_queue,
    input logic [LENW-1:0] deq_len,
    input logic [NQ-1:0]   q_ne,
    input logic [NQ-1:0]   q_pop
);
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (deq_valid && !deq_ready) |=> (deq_valid && $stable(deq_queue) && $stable(deq_len)));

    a_r8_frozen: assert property (@(posedge clk) disable iff (rst)
        !deq_ready |-> (q_pop == '0));

    a_r2_bad_class: assert property (@(posedge clk) disable iff (rst)
        (enq_class == 2'd3) |-> !enq_ready);

    a_r1_single_pop: assert property (@(posedge clk) disable iff (rst)
        $onehot0(q_pop));

    a_r4_early_first: assert property (@(posedge clk) disable iff (rst)
        q_pop[1] |-> !q_ne[0]);

    a_r10_no_empty_pop: assert property (@(posedge clk) disable iff (rst)
        (q_pop & ~q_ne) == '0);

    a_r9_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !deq_valid);
endmodule

bind tri_class_scheduler tcs_checker #(.NQ(NQ), .QIDW(QIDW), .LENW(LENW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .enq_class (enq_class),
    .enq_ready (enq_ready),
    .deq_valid (deq_valid),
    .deq_ready (deq_ready),
    .deq_queue (deq_queue),
    .deq_len   (deq_len),
    .q_ne      (q_ne),
    .q_pop     (q_pop)
);

// File: tb/tri_class_scheduler_test.sv
module tri_class_scheduler_test;
    localparam int LENW  = 10;
    localparam int BW    = 12;
    localparam int FLOWS = 2;
    localparam int DEPTH = 4;
    localparam int NQ    = 2 + 2 * FLOWS;
    localparam int ND    = 2 * FLOWS;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    enq_valid = 1'b0;
    logic [1:0]              enq_class = '0;
    logic [0:0]              enq_sub = '0;
    logic [LENW-1:0]         enq_len = '0;
    logic                    enq_ready;
    logic [BW-1:0]           cfg_slot_budget = 12'd1000;
    logic [ND*LENW-1:0]      cfg_quantum = '0;
    logic                    deq_valid;
    logic                    deq_ready = 1'b0;
    logic [2:0]              deq_queue;
    logic [LENW-1:0]         deq_len;

    always #2 clk = ~clk;

    tri_class_scheduler #(.LENW(LENW), .BW(BW), .FLOWS(FLOWS), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .enq_valid(enq_valid), .enq_class(enq_class),
        .enq_sub(enq_sub), .enq_len(enq_len), .enq_ready(enq_ready),
        .cfg_slot_budget(cfg_slot_budget), .cfg_quantum(cfg_quantum),
        .deq_valid(deq_valid), .deq_ready(deq_ready),
        .deq_queue(deq_queue), .deq_len(deq_len)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // Bench model state
    int mq [NQ][$];
    int m_slot, m_budget, m_fresh, m_cfg_budget;
    int m_ptr [2];
    int m_cred [2];
    int m_def [ND];
    int m_quant [ND];
    int exp_q [$];
    int exp_l [$];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic int frame_cls(input int s);
        if (s == 5) return 2;
        return (s % 2 == 0) ? 0 : 1;
    endfunction

    task automatic set_cfg(input int budget, input int q0, input int q1,
                           input int q2, input int q3);
        m_cfg_budget = budget;
        m_quant[0] = q0; m_quant[1] = q1; m_quant[2] = q2; m_quant[3] = q3;
        cfg_slot_budget = BW'(budget);
        for (int j = 0; j < ND; j++) cfg_quantum[j*LENW +: LENW] = LENW'(m_quant[j]);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        deq_ready = 1'b0;
        enq_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_slot = 0; m_budget = m_cfg_budget; m_fresh = 1;
        for (int j = 0; j < 2; j++) begin m_ptr[j] = 0; m_cred[j] = 0; end
        for (int j = 0; j < ND; j++) m_def[j] = 0;
        for (int j = 0; j < NQ; j++) mq[j].delete();
        exp_q.delete(); exp_l.delete();
        @(negedge clk);
        check(deq_valid == 1'b0, "R9", "deq_valid after reset", int'(deq_valid), 0);
    endtask

    task automatic enq(input int cls, input int sub, input int len);
        int tgt;
        bit exp_rdy;
        @(negedge clk);
        enq_valid = 1'b1;
        enq_class = 2'(cls);
        enq_sub   = 1'(sub);
        enq_len   = LENW'(len);
        tgt = (cls == 0) ? sub : (cls == 1) ? 2 + sub : 2 + FLOWS + sub;
        exp_rdy = (cls != 3) && (mq[tgt].size() < DEPTH);
        #1;
        if (cls == 3)
            check(enq_ready == exp_rdy, "R2", "enq_ready invalid class", int'(enq_ready), int'(exp_rdy));
        else if (!exp_rdy)
            check(enq_ready == exp_rdy, "R10", "enq_ready full queue", int'(enq_ready), int'(exp_rdy));
        else
            check(enq_ready == exp_rdy, "R1", "enq_ready", int'(enq_ready), int'(exp_rdy));
        if (exp_rdy) mq[tgt].push_back(len);
        @(posedge clk);
        #1;
        enq_valid = 1'b0;
    endtask

    task automatic m_next_slot();
        m_slot = (m_slot + 1) % 6;
        m_budget = m_cfg_budget;
        m_fresh = 1;
    endtask

    task automatic m_send(input int q);
        int len;
        len = mq[q][0];
        exp_q.push_back(q);
        exp_l.push_back(len);
        m_budget = (len <= m_budget) ? m_budget - len : 0;
        m_fresh = 0;
        void'(mq[q].pop_front());
    endtask

    // Reference model of the frame, built from R3..R7.
    task automatic model_run();
        int guard;
        guard = 0;
        while (guard < 100000) begin
            bit b1, b2, b3;
            int eff, c;
            b1 = (mq[0].size() + mq[1].size()) > 0;
            b2 = (mq[2].size() + mq[3].size()) > 0;
            b3 = (mq[4].size() + mq[5].size()) > 0;
            if (!b1 && !b2 && !b3) break;
            guard++;
            c = frame_cls(m_slot);
            eff = 3;
            if (c == 0 && b1) eff = 0;
            else if (c == 1 && b2) eff = 1;
            else if (b3) eff = 2;
            if (eff == 3) m_next_slot();
            else if (eff == 0) begin
                int q;
                q = (mq[0].size() > 0) ? 0 : 1;
                if (m_fresh != 0 || mq[q][0] <= m_budget) m_send(q);
                else m_next_slot();
            end else begin
                int k, d, q;
                k = (eff == 2) ? 1 : 0;
                d = k * FLOWS + m_ptr[k];
                q = 2 + d;
                if (mq[q].size() == 0) begin
                    m_def[d] = 0; m_ptr[k] = (m_ptr[k] + 1) % FLOWS; m_cred[k] = 0;
                end else if (m_cred[k] == 0) begin
                    m_def[d] += m_quant[d]; m_cred[k] = 1;
                end else if (mq[q][0] > m_def[d]) begin
                    m_ptr[k] = (m_ptr[k] + 1) % FLOWS; m_cred[k] = 0;
                end else if (!(m_fresh != 0 || mq[q][0] <= m_budget)) begin
                    m_next_slot();
                end else begin
                    m_def[d] -= mq[q][0];
                    m_send(q);
                    if (mq[q].size() == 0) begin
                        m_def[d] = 0; m_ptr[k] = (m_ptr[k] + 1) % FLOWS; m_cred[k] = 0;
                    end
                end
            end
        end
    endtask

    task automatic expect_order(input string req, input int lit[$]);
        check(exp_q.size() == lit.size(), req, "departure count", exp_q.size(), lit.size());
        for (int i = 0; i < lit.size() && i < exp_q.size(); i++)
            check(exp_q[i] == lit[i], req, $sformatf("queue of departure %0d", i), exp_q[i], lit[i]);
    endtask

    task automatic drain(input string req, input bit stall);
        int got, cyc;
        got = 0; cyc = 0;
        @(negedge clk);
        deq_ready = 1'b1;
        while (got < exp_q.size() && cyc < 6000) begin
            @(negedge clk);
            cyc++;
            if (deq_valid) begin
                check(int'(deq_queue) == exp_q[got], req, "deq_queue", int'(deq_queue), exp_q[got]);
                check(int'(deq_len) == exp_l[got], req, "deq_len", int'(deq_len), exp_l[got]);
                got++;
                if (stall && got == 2) begin
                    logic [2:0] hq;
                    logic [LENW-1:0] hl;
                    hq = deq_queue; hl = deq_len;
                    deq_ready = 1'b0;
                    repeat (5) @(negedge clk);
                    check(deq_valid && deq_queue == hq && deq_len == hl, "R8",
                          "descriptor held under stall", int'(deq_len), int'(hl));
                    deq_ready = 1'b1;
                end
            end
        end
        check(got == exp_q.size(), "R7", "descriptors delivered", got, exp_q.size());
        begin
            int extra;
            extra = 0;
            repeat (30) begin
                @(negedge clk);
                if (deq_valid) extra++;
            end
            check(extra == 0, "R1", "extra descriptors", extra, 0);
        end
        deq_ready = 1'b0;
        exp_q.delete(); exp_l.delete();
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        set_cfg(1000, 100, 100, 100, 100);
        do_reset();

        // R9: nothing queued, egress ready, no output
        @(negedge clk);
        deq_ready = 1'b1;
        repeat (10) @(negedge clk);
        check(deq_valid == 1'b0, "R9", "idle with empty queues", int'(deq_valid), 0);
        deq_ready = 1'b0;

        // R4: later-deadline packets queued first, earlier ones still leave first
        enq(0, 1, 50); enq(0, 1, 51); enq(0, 0, 60); enq(0, 0, 61);
        model_run();
        expect_order("R4", '{0, 0, 1, 1});
        drain("R4", 1'b1);

        // R3: one packet per slot shows the frame order
        set_cfg(100, 100, 100, 100, 100);
        do_reset();
        enq(0, 0, 100); enq(0, 0, 100); enq(0, 0, 100);
        enq(1, 0, 100); enq(1, 0, 100);
        enq(2, 0, 100);
        model_run();
        expect_order("R3", '{0, 2, 0, 2, 0, 4});
        drain("R3", 1'b0);

        // R6: quantum 100 against 300 between two non-real-time flows
        set_cfg(4000, 100, 300, 100, 100);
        do_reset();
        for (int i = 0; i < 4; i++) begin enq(1, 0, 100); enq(1, 1, 100); end
        model_run();
        expect_order("R6", '{2, 3, 3, 3, 2, 3, 2, 2});
        drain("R6", 1'b0);

        // R5 and R7: budget ends the real-time slot, free slot goes to best effort
        set_cfg(150, 100, 100, 200, 100);
        do_reset();
        enq(0, 0, 100); enq(0, 0, 100); enq(2, 0, 100);
        model_run();
        expect_order("R5", '{0, 4, 0});
        drain("R5", 1'b0);

        // R6: deficit cleared when a flow empties, then the flow is refilled
        set_cfg(4000, 150, 100, 100, 100);
        do_reset();
        enq(1, 0, 100);
        model_run();
        expect_order("R6", '{2});
        drain("R6", 1'b0);
        enq(1, 0, 100); enq(1, 0, 100); enq(1, 1, 100); enq(1, 1, 100);
        model_run();
        expect_order("R6", '{3, 2, 3, 2});
        drain("R6", 1'b0);

        // R2: invalid class dropped
        set_cfg(1000, 100, 100, 100, 100);
        do_reset();
        enq(3, 0, 77); enq(3, 1, 78);
        model_run();
        drain("R2", 1'b0);

        // R10: fifth descriptor into a full queue is dropped
        for (int i = 0; i < DEPTH + 1; i++) enq(1, 1, 20 + i);
        model_run();
        expect_order("R10", '{3, 3, 3, 3});
        drain("R10", 1'b0);

        // Random loads with random budgets and quanta (R1, R3, R5, R6, R7)
        for (int r = 0; r < 10; r++) begin
            set_cfg(64 + int'($urandom % 900), 32 + int'($urandom % 400),
                    32 + int'($urandom % 400), 32 + int'($urandom % 400),
                    32 + int'($urandom % 400));
            do_reset();
            for (int n = 0; n < 30; n++) begin
                int cls;
                cls = int'($urandom % 8);
                if (cls > 3) cls = cls % 3;
                enq(cls, int'($urandom % 2), 16 + int'($urandom % 500));
            end
            model_run();
            drain("R1", r == 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL R7 watchdog expired: actual %0d expected %0d", 190000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule